// File: doc/BRIEF.md
# Grouped fixed-priority interrupt arbiter

This block picks one winner out of a wide vector of interrupt request lines under a strict fixed priority: line 0 is most urgent and urgency drops with every step up in index. It returns a one-hot grant vector of the same width, a flag that is high whenever any line is asserted, and the binary position of the winning line. It is meant to sit in the request path of an interrupt controller, where the requester must learn in the same clock cycle whether it has won.

To keep the logic depth short, the lines are cut into small groups. Each group resolves its own winner and flags whether it holds any active line. A second select over those flags picks the lowest-numbered busy group, and that choice gates the group-local grants and builds the index. The last group holds only the lines that remain, so positions beyond the request width have no logic. The group size is a parameter (5 or 6 are the intended settings). A second parameter puts rising-edge registers on the request input and on all results.

Top module: `irq_tree_arb`

## Requirements
- R1: With 27 request lines, the single granted line is the lowest-index line whose request is high.
- R2: The grant vector has at most one bit set, and a set grant bit always has its request bit set.
- R3: `valid_o` is 1 exactly when at least one request line is high.
- R4: When `valid_o` is 1, `idx_o` holds the binary position of the set grant bit.
- R5: With no request line high, `gnt_o` is all zeros, `valid_o` is 0 and `idx_o` is 0.
- R6: Group sizes of 5 and of 6 give identical grant, valid and index results for every request vector.
- R7: With `REG_IO` = 0 (default) the path from `req_i` to all results is combinational: a request change is reflected before the next rising clock edge, with no clock edge needed.
- R8: With `REG_IO` = 1 requests are captured on a rising edge and the results are registered on the following rising edge, so the results for a request vector appear after the second rising edge that follows its presentation.
- R9: With `REG_IO` = 1, while `rst_ni` is low all registered results read zero regardless of the requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge; used only when `REG_IO` = 1 |
| rst_ni | input | 1 | Asynchronous reset, active low; used only when `REG_IO` = 1 |
| req_i | input | NUM_REQ (27) | Request lines, bit 0 most urgent |
| gnt_o | output | NUM_REQ (27) | One-hot grant, all zeros when idle |
| valid_o | output | 1 | High when a grant is issued |
| idx_o | output | IDX_W (5) | Binary position of the granted line, 0 when idle |

## Verification
In the default build every result is due in the same cycle as its request: the bench changes the requests one time unit after a rising edge and samples grant, valid and index four time units later, before the next edge, so no register can be involved. The grouped instances of size 5 and size 6 are sampled at that same point and compared with a flat lowest-index reference. The registered instance sees the same stream, and its results are compared with the request vector applied two iterations earlier, since the input capture and the output register each cost one rising edge; a history kept in the bench supplies that vector, and zeros fill the first two slots after reset.

// File: rtl/arb_tree_pkg.sv
package arb_tree_pkg;

  // Width of a binary index able to address n positions (at least one bit).
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/arb_leaf_sel.sv
// Small flat fixed-priority select: lowest set bit wins.
module arb_leaf_sel #(
  parameter int W = 5
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] sel_o,
  output logic         any_o
);

  logic blocked;

  always_comb begin
    sel_o   = '0;
    blocked = 1'b0;
    for (int i = 0; i < W; i++) begin
      sel_o[i] = req_i[i] & ~blocked;
      blocked  = blocked | req_i[i];
    end
    any_o = blocked;
  end

endmodule

// File: rtl/arb_oh_enc.sv
// One-hot to binary encoder built as an OR of constants.
module arb_oh_enc
  import arb_tree_pkg::*;
#(
  parameter  int W  = 5,
  localparam int LW = idx_w(W)
) (
  input  logic [W-1:0]  oh_i,
  output logic [LW-1:0] bin_o
);

  always_comb begin
    bin_o = '0;
    for (int i = 0; i < W; i++) begin
      bin_o = bin_o | (oh_i[i] ? LW'(i) : '0);
    end
  end

endmodule

// File: rtl/arb_tree_core.sv
// Two-level arbitration: group-local select, then select among groups.
module arb_tree_core
  import arb_tree_pkg::*;
#(
  parameter  int NUM_REQ  = 27,
  parameter  int GRP_SIZE = 5,
  localparam int NUM_GRP  = (NUM_REQ + GRP_SIZE - 1) / GRP_SIZE,
  localparam int IDX_W    = idx_w(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [NUM_GRP-1:0] grp_any;
  logic [NUM_GRP-1:0] grp_sel;
  logic [IDX_W-1:0]   cand_gated [NUM_GRP];

  // Second level: lowest-numbered busy group wins.
  arb_leaf_sel #(.W(NUM_GRP)) u_grp_sel (
    .req_i (grp_any),
    .sel_o (grp_sel),
    .any_o (valid_o)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    // The last group only holds the lines that are left over.
    localparam int GW   = (g == NUM_GRP - 1) ? (NUM_REQ - g * GRP_SIZE) : GRP_SIZE;
    localparam int LW   = idx_w(GW);
    localparam int BASE = g * GRP_SIZE;

    logic [GW-1:0] loc_sel;
    logic [LW-1:0] loc_idx;
    logic          loc_any;

    arb_leaf_sel #(.W(GW)) u_loc_sel (
      .req_i (req_i[BASE +: GW]),
      .sel_o (loc_sel),
      .any_o (loc_any)
    );

    arb_oh_enc #(.W(GW)) u_loc_enc (
      .oh_i  (loc_sel),
      .bin_o (loc_idx)
    );

    assign grp_any[g]           = loc_any;
    assign gnt_o[BASE +: GW]    = loc_sel & {GW{grp_sel[g]}};
    // Group offset added in parallel with the group-level select.
    assign cand_gated[g]        = grp_sel[g] ? (IDX_W'(BASE) + IDX_W'(loc_idx)) : '0;
  end

  always_comb begin
    idx_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      idx_o = idx_o | cand_gated[g];
    end
  end

endmodule

// File: rtl/irq_tree_arb.sv
// Top: grouped fixed-priority arbiter with optional I/O registers.
module irq_tree_arb
  import arb_tree_pkg::*;
#(
  parameter  int NUM_REQ  = 27,
  parameter  int GRP_SIZE = 5,
  parameter  bit REG_IO   = 1'b0,
  localparam int IDX_W    = idx_w(NUM_REQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [NUM_REQ-1:0] core_req;
  logic [NUM_REQ-1:0] core_gnt;
  logic               core_valid;
  logic [IDX_W-1:0]   core_idx;

  arb_tree_core #(
    .NUM_REQ  (NUM_REQ),
    .GRP_SIZE (GRP_SIZE)
  ) u_core (
    .req_i   (core_req),
    .gnt_o   (core_gnt),
    .valid_o (core_valid),
    .idx_o   (core_idx)
  );

  if (REG_IO) begin : g_reg
    logic [NUM_REQ-1:0] req_d,   req_q;
    logic [NUM_REQ-1:0] gnt_d,   gnt_q;
    logic               valid_d, valid_q;
    logic [IDX_W-1:0]   idx_d,   idx_q;

    // Next-state
    always_comb begin
      req_d   = req_i;
      gnt_d   = core_gnt;
      valid_d = core_valid;
      idx_d   = core_idx;
    end

    // Registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q   <= '0;
        gnt_q   <= '0;
        valid_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        req_q   <= req_d;
        gnt_q   <= gnt_d;
        valid_q <= valid_d;
        idx_q   <= idx_d;
      end
    end

    assign core_req = req_q;
    assign gnt_o    = gnt_q;
    assign valid_o  = valid_q;
    assign idx_o    = idx_q;
  end else begin : g_comb
    assign core_req = req_i;
    assign gnt_o    = core_gnt;
    assign valid_o  = core_valid;
    assign idx_o    = core_idx;
  end

endmodule

// File: rtl/arb_tree_chk.sv
// Property checker for irq_tree_arb, attached with bind below.
module arb_tree_chk #(
  parameter int NUM_REQ = 27,
  parameter bit REG_IO  = 1'b0,
  parameter int IDX_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] req_i,
  input logic [NUM_REQ-1:0] gnt_o,
  input logic               valid_o,
  input logic [IDX_W-1:0]   idx_o
);

  // Requests the current results must correspond to.
  logic [NUM_REQ-1:0] ref_req;

  if (REG_IO) begin : g_dly
    logic [NUM_REQ-1:0] st1, st2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st1 <= '0;
        st2 <= '0;
      end else begin
        st1 <= req_i;
        st2 <= st1;
      end
    end
    assign ref_req = st2;
  end else begin : g_nodly
    assign ref_req = req_i;
  end

  // R2
  onehot_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R2
  grant_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~ref_req) == '0);

  // R1
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req & (gnt_o - NUM_REQ'(1))) == '0);

  // R3
  valid_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (|ref_req));

  // R4
  idx_points_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (((gnt_o >> idx_o) & NUM_REQ'(1)) != '0));

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (idx_o == '0 && gnt_o == '0));

endmodule

bind irq_tree_arb arb_tree_chk #(
  .NUM_REQ (NUM_REQ),
  .REG_IO  (REG_IO),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .gnt_o   (gnt_o),
  .valid_o (valid_o),
  .idx_o   (idx_o)
);

// File: tb/irq_tree_arb_tb_top.sv
`timescale 1ns/1ps
module irq_tree_arb_tb_top;

  localparam int N  = 27;
  localparam int IW = 5;
  localparam int NT = 12;

  // Directed table: request vector and expected winner (valid, index).
  localparam logic [N-1:0] TAB_REQ [NT] = '{
    27'h0000000, 27'h0000001, 27'h4000000, 27'h7FFFFFF,
    27'h7FFFFFE, 27'h4000020, 27'h0000060, 27'h0000010,
    27'h6000000, 27'h0100000, 27'h3000000, 27'h0001800
  };
  localparam bit TAB_VLD [NT] = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam int TAB_IDX [NT] = '{0, 0, 26, 0, 1, 5, 5, 4, 25, 20, 24, 11};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  req;
  logic [N-1:0]  g5, g6, gr;
  logic          v5, v6, vr;
  logic [IW-1:0] i5, i6, ir;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [N-1:0] h1, h2;

  irq_tree_arb #(.NUM_REQ(N), .GRP_SIZE(5), .REG_IO(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(g5), .valid_o(v5), .idx_o(i5));
  irq_tree_arb #(.NUM_REQ(N), .GRP_SIZE(6), .REG_IO(1'b0)) dut6_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(g6), .valid_o(v6), .idx_o(i6));
  irq_tree_arb #(.NUM_REQ(N), .GRP_SIZE(5), .REG_IO(1'b1)) dutr_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gr), .valid_o(vr), .idx_o(ir));

  function automatic logic [IW-1:0] ref_idx(logic [N-1:0] r);
    logic [IW-1:0] w = '0;
    for (int i = N - 1; i >= 0; i--) if (r[i]) w = IW'(i);
    return w;
  endfunction

  function automatic logic [N-1:0] ref_gnt(logic [N-1:0] r);
    return (|r) ? (N'(1) << ref_idx(r)) : '0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply one vector after a rising edge, sample before the next one.
  task automatic step(logic [N-1:0] r);
    @(posedge clk);
    #1 req = r;
    #4;
    // R1 R7: combinational winner already settled in this cycle
    chk("R1/R7 grant gs5", 64'(g5), 64'(ref_gnt(r)));
    chk("R3 valid gs5",    64'(v5), 64'(|r));
    chk("R4 index gs5",    64'(i5), 64'(ref_idx(r)));
    // R6: size-6 grouping agrees
    chk("R6 grant gs6",    64'(g6), 64'(ref_gnt(r)));
    chk("R6 valid gs6",    64'(v6), 64'(|r));
    chk("R6 index gs6",    64'(i6), 64'(ref_idx(r)));
    // R8: registered build shows the vector from two edges back
    chk("R8 grant reg",    64'(gr), 64'(ref_gnt(h2)));
    chk("R8 valid reg",    64'(vr), 64'(|h2));
    chk("R8 index reg",    64'(ir), 64'(ref_idx(h2)));
    h2 = h1;
    h1 = r;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req   = '1;
    h1    = '0;
    h2    = '0;
    repeat (3) @(posedge clk);
    #5;
    // R9: registered results held at zero during reset despite requests
    chk("R9 grant in reset", 64'(gr), 64'(0));
    chk("R9 valid in reset", 64'(vr), 64'(0));
    chk("R9 index in reset", 64'(ir), 64'(0));
    // R7: combinational build works without reset or clock
    chk("R7 grant all-ones", 64'(g5), 64'(N'(1)));
    req = '0;
    #1;
    // R5: idle outputs
    chk("R5 idle grant", 64'(g5), 64'(0));
    chk("R5 idle valid", 64'(v5), 64'(0));
    chk("R5 idle index", 64'(i5), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1 R3 R4 R5 against table expectations
    for (int t = 0; t < NT; t++) begin
      step(TAB_REQ[t]);
      chk("R3 table valid", 64'(v5), 64'(TAB_VLD[t]));
      chk("R4 table index", 64'(i5), 64'(TAB_IDX[t]));
      chk("R1 table grant", 64'(g5),
          TAB_VLD[t] ? 64'(N'(1) << TAB_IDX[t]) : 64'(0));
    end

    // R1 every single line, including group boundaries and the top line
    for (int b = 0; b < N; b++) step(N'(1) << b);
    // R2 each line with every higher-index line also set
    for (int b = 0; b < N; b++) step(~((N'(1) << b) - N'(1)));

    // Random vectors with several densities
    for (int k = 0; k < 10000; k++) begin
      logic [N-1:0] r;
      r = N'($urandom());
      case (k % 4)
        1: r = r & N'($urandom());
        2: r = r & N'($urandom()) & N'($urandom());
        3: r = r << (k % N);
        default: ;
      endcase
      step(r);
    end

    // Drain: registered build returns to idle (R5 R8)
    step('0);
    step('0);
    step('0);
    chk("R5 reg idle", 64'(vr), 64'(0));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule